// File: doc/BRIEF.md
# Multiprocessor-Capable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port that a processor drives through two byte-wide register locations. Location 0 is the data register. A write to it loads the transmitter and starts a frame at once. A read from it returns the most recently accepted received byte. Location 1 is the control register. It holds the frame mode, the multiprocessor filter enable, the outgoing and incoming ninth bits, and the two sticky completion flags. The two flags also appear on pins, as interrupt requests for an interrupt controller outside the block.

Three frame formats are available:
- 8 data bits at a variable rate.
- 9 bits at a fixed fraction of the system clock.
- 9 bits at a variable rate.

The variable rate comes from an external tick at sixteen times the bit rate. The receiver samples each bit sixteen times and takes a majority of the three centre samples. In the 9-bit formats the multiprocessor filter can be switched on. Only frames whose ninth bit is 1, the address frames, then raise the receive flag. Software on a listening node compares the address. When the address matches, it turns the filter off so that it takes in the data frames that follow.

The register interface has no back-pressure. A write to the data register while a frame is still leaving is dropped. Software waits for the transmit flag before it writes the next byte. A new received byte overwrites the buffer whether or not the previous one was read.

Top module: `serial_port_mp`

## Requirements
- R1: Register location 0 (bus_addr=0) is the data register: a write starts a transmission of bus_wdata, a read returns the receive buffer. Location 1 is control, with bits [7:6] mode, [5] multiprocessor enable, [4] reads 0, [3] transmit ninth bit, [2] received ninth bit (read-only), [1] transmit-done flag, [0] receive-done flag.
- R2: When no frame is leaving, txd is 1. A frame starts with one 0 bit, sends the data bits LSB first, and ends with one 1 bit. Mode 0 frames are 10 bits long.
- R3: Mode values 1, 2 and 3 are 9-bit formats. The control bit [3] value is sent after bit 7 and before the stop bit, which makes 11 bits.
- R4: In modes 0, 2 and 3 every bit lasts 16 baud_tick pulses. In mode 1 a bit lasts 32 clocks when rate_double=1 and 64 clocks when rate_double=0.
- R5: A data-register write while a frame is leaving is ignored: the current frame completes unchanged and no second frame follows.
- R6: The transmit-done flag (control bit 1, tx_irq) sets when the stop bit ends. It stays set until software writes 0 to it.
- R7: A received frame is assembled LSB first. On acceptance the byte enters the receive buffer and the receive-done flag (control bit 0, rx_irq) sets. In the 9-bit formats the ninth bit is copied into control bit 2.
- R8: A low pulse on rxd that is no longer low at the middle of the start bit starts no frame and sets no flag.
- R9: In mode 0 a frame whose stop bit is sampled 0 is dropped: the flag stays clear and the buffer keeps its old value. The 9-bit formats do not check the stop bit.
- R10: In a 9-bit format with control bit 5 set, a frame whose ninth bit is 0 is dropped. Frames with ninth bit 1 are accepted. Mode 0 ignores control bit 5.
- R11: A frame accepted while the receive-done flag is still set overwrites the buffer, and the flag stays set.
- R12: The transmitter and the receiver run at the same time without affecting each other.
- R13: After reset, both registers read 0, txd is 1 and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 data, 1 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| rate_double | input | 1 | Selects the faster fixed rate in mode 1 |
| baud_tick | input | 1 | Single-cycle pulse at 16 times the variable bit rate |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| tx_irq | output | 1 | Transmit-done flag |
| rx_irq | output | 1 | Receive-done flag |

## Verification
The assertions assume that baud_tick pulses last one clock and that the mode and filter bits do not change while a frame is moving. The rxd line must stay in step with one bit period per frame. The bench keeps within these limits in three ways. It writes the control register only while both directions are idle. It makes ticks from a fixed three-clock divider. It drives every received bit for exactly the bit length of the mode in use, except in the deliberate glitch and bad-stop cases.

// File: rtl/serial_port_mp_pkg.sv
package serial_port_mp_pkg;
  typedef enum logic [1:0] {
    FMT_8_VAR   = 2'd0,
    FMT_9_FIX   = 2'd1,
    FMT_9_VAR   = 2'd2,
    FMT_9_VAR_B = 2'd3
  } frame_fmt_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_NINTH, RX_STOP
  } rx_state_e;

  function automatic logic fmt_is_nine(input frame_fmt_e f);
    return f != FMT_8_VAR;
  endfunction
endpackage

// File: rtl/sp_tick_sel.sv
module sp_tick_sel #(
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_fixed,
  input  logic rate_double,
  input  logic baud_tick,
  output logic os_tick
);
  localparam int DW   = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam int HALF = SLOW_DIV / 2;
  localparam logic [DW-1:0] LAST  = DW'(SLOW_DIV - 1);
  localparam logic [DW-1:0] MIDPT = DW'(HALF - 1);

  logic [DW-1:0] div_q;
  logic slow_hit, fast_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  assign slow_hit = (div_q == LAST);
  assign fast_hit = slow_hit || (div_q == MIDPT);
  assign os_tick  = use_fixed ? (rate_double ? fast_hit : slow_hit) : baud_tick;
endmodule

// File: rtl/sp_tx.sv
module sp_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic              nine_en,
  input  logic              ninth,
  output logic              txd,
  output logic              busy,
  output logic              fin
);
  localparam int FW = DATA_W + 3;
  localparam int LW = $clog2(FW + 1);
  localparam int CW = $clog2(OVS);
  localparam logic [LW-1:0] LEN9 = LW'(FW);
  localparam logic [LW-1:0] LEN8 = LW'(FW - 1);
  localparam logic [CW-1:0] CLAST = CW'(OVS - 1);

  logic [FW-1:0] sh_q;
  logic [LW-1:0] left_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      busy   <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start && !busy) begin
        sh_q   <= {1'b1, (nine_en ? ninth : 1'b1), data, 1'b0};
        left_q <= nine_en ? LEN9 : LEN8;
        cnt_q  <= '0;
        busy   <= 1'b1;
      end else if (busy && os_tick) begin
        if (cnt_q == CLAST) begin
          cnt_q <= '0;
          if (left_q == LW'(1)) begin
            busy <= 1'b0;
            fin  <= 1'b1;
          end else begin
            sh_q   <= {1'b1, sh_q[FW-1:1]};
            left_q <= left_q - 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign txd = busy ? sh_q[0] : 1'b1;
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import serial_port_mp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              nine_en,
  input  logic              mp_en,
  output logic              accept,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ninth
);
  localparam int CW  = $clog2(OVS);
  localparam int IW  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] S_A  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] S_B  = CW'(OVS / 2);
  localparam logic [CW-1:0] S_C  = CW'(OVS / 2 + 1);
  localparam logic [IW-1:0] ILAST = IW'(DATA_W - 1);

  rx_state_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic              smp_a, smp_b, ninth_q;
  logic [DATA_W-1:0] sh_q;
  logic              vote;

  assign vote = (smp_a & smp_b) | (smp_a & rxd) | (smp_b & rxd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RX_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      smp_a    <= 1'b1;
      smp_b    <= 1'b1;
      ninth_q  <= 1'b0;
      sh_q     <= '0;
      accept   <= 1'b0;
      rx_data  <= '0;
      rx_ninth <= 1'b0;
    end else begin
      accept <= 1'b0;
      if (os_tick) begin
        if (st_q == RX_IDLE) begin
          if (!rxd) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == S_A) smp_a <= rxd;
          if (cnt_q == S_B) smp_b <= rxd;
          if (cnt_q == S_C) begin
            unique case (st_q)
              RX_START: begin
                if (vote) st_q <= RX_IDLE;
                else begin
                  st_q  <= RX_DATA;
                  idx_q <= '0;
                end
              end
              RX_DATA: begin
                sh_q <= {vote, sh_q[DATA_W-1:1]};
                if (idx_q == ILAST) st_q <= nine_en ? RX_NINTH : RX_STOP;
                else idx_q <= idx_q + 1'b1;
              end
              RX_NINTH: begin
                ninth_q <= vote;
                st_q    <= RX_STOP;
              end
              RX_STOP: begin
                st_q <= RX_IDLE;
                if (nine_en ? (!mp_en || ninth_q) : vote) begin
                  accept  <= 1'b1;
                  rx_data <= sh_q;
                  if (nine_en) rx_ninth <= ninth_q;
                end
              end
              default: st_q <= RX_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_port_mp.sv
module serial_port_mp
  import serial_port_mp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int OVS      = 16,
  parameter int SLOW_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rate_double,
  input  logic              baud_tick,
  input  logic              rxd,
  output logic              txd,
  output logic              tx_irq,
  output logic              rx_irq
);
  frame_fmt_e        mode_q;
  logic              mp_en_q, tx9_q, tx_done_q, rx_done_q;
  logic              rxd_m, rxd_s;
  logic              wr_data, wr_ctrl, os_tick, nine_en;
  logic              tx_busy, tx_fin, rx_accept, rx9;
  logic [DATA_W-1:0] rx_buf;
  logic              ctrl_unused;

  assign wr_data     = bus_wr && !bus_addr;
  assign wr_ctrl     = bus_wr && bus_addr;
  assign nine_en     = fmt_is_nine(mode_q);
  assign ctrl_unused = ^{bus_wdata[4], bus_wdata[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= FMT_8_VAR;
      mp_en_q   <= 1'b0;
      tx9_q     <= 1'b0;
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode_q  <= frame_fmt_e'(bus_wdata[7:6]);
        mp_en_q <= bus_wdata[5];
        tx9_q   <= bus_wdata[3];
      end
      tx_done_q <= tx_fin    ? 1'b1 : (wr_ctrl ? bus_wdata[1] : tx_done_q);
      rx_done_q <= rx_accept ? 1'b1 : (wr_ctrl ? bus_wdata[0] : rx_done_q);
    end
  end

  sp_tick_sel #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .use_fixed(mode_q == FMT_9_FIX),
    .rate_double(rate_double), .baud_tick(baud_tick), .os_tick(os_tick)
  );

  sp_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .start(wr_data),
    .data(bus_wdata), .nine_en(nine_en), .ninth(tx9_q),
    .txd(txd), .busy(tx_busy), .fin(tx_fin)
  );

  sp_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd_s),
    .nine_en(nine_en), .mp_en(mp_en_q), .accept(rx_accept),
    .rx_data(rx_buf), .rx_ninth(rx9)
  );

  generate
    if (DATA_W >= 8) begin : g_ctrl_wide
      always_comb begin
        bus_rdata = '0;
        if (!bus_addr) bus_rdata = rx_buf;
        else bus_rdata[7:0] = {mode_q, mp_en_q, 1'b0, tx9_q, rx9, tx_done_q, rx_done_q};
      end
    end else begin : g_ctrl_narrow
      logic [7:0] ctrl_full;
      assign ctrl_full = {mode_q, mp_en_q, 1'b0, tx9_q, rx9, tx_done_q, rx_done_q};
      assign bus_rdata = bus_addr ? ctrl_full[DATA_W-1:0] : rx_buf;
    end
  endgenerate

  assign tx_irq = tx_done_q;
  assign rx_irq = rx_done_q;
endmodule

// File: rtl/serial_port_mp_checker.sv
module serial_port_mp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       tx_busy,
  input logic       tx_irq,
  input logic       rx_irq,
  input logic       rx9,
  input logic       wr_ctrl,
  input logic       mp_en,
  input logic [1:0] mode
);
  AST_TXD_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R2
  AST_TX_START_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd); // R2
  AST_TX_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |=> tx_irq); // R6
  AST_TX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq && !wr_ctrl |=> tx_irq); // R6
  AST_RX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq && !wr_ctrl |=> rx_irq); // R11
  AST_MP_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) && !$past(wr_ctrl) && $past(mp_en) && ($past(mode) != 2'd0) |-> rx9); // R10
endmodule

bind serial_port_mp serial_port_mp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .tx_irq(tx_irq),
  .rx_irq(rx_irq), .rx9(rx9), .wr_ctrl(wr_ctrl), .mp_en(mp_en_q), .mode(mode_q)
);

// File: tb/serial_port_mp_bench.sv
module serial_port_mp_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rate_double = 1'b1;
  logic       baud_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       txd, tx_irq, rx_irq;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  serial_port_mp u_serial_port_mp (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rate_double(rate_double),
    .baud_tick(baud_tick), .rxd(rxd), .txd(txd), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  initial begin
    forever begin
      repeat (2) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  // vector: mode[13:12] mp[11] ninth[10] data[9:2] stop[1] expect_accept[0]
  localparam logic [13:0] VEC [9] = '{
    {2'd0, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b1},
    {2'd0, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b1},
    {2'd0, 1'b0, 1'b0, 8'h7E, 1'b0, 1'b0},
    {2'd2, 1'b0, 1'b0, 8'h81, 1'b1, 1'b1},
    {2'd2, 1'b1, 1'b0, 8'h55, 1'b1, 1'b0},
    {2'd2, 1'b1, 1'b1, 8'h12, 1'b1, 1'b1},
    {2'd1, 1'b0, 1'b1, 8'hC3, 1'b1, 1'b1},
    {2'd1, 1'b1, 1'b0, 8'hF0, 1'b0, 1'b0},
    {2'd3, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1}
  };

  function automatic int bit_clks(input logic [1:0] m, input logic dbl);
    if (m == 2'd1) return dbl ? 32 : 64;
    return 48;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic send_frame(input int bc, input logic nine, input logic [7:0] d,
                            input logic n9, input logic stp);
    rxd = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (bc) @(negedge clk);
    end
    if (nine) begin
      rxd = n9;
      repeat (bc) @(negedge clk);
    end
    rxd = stp;
    repeat (bc) @(negedge clk);
    rxd = 1'b1;
  endtask

  // call right after wr() returned from a data write
  task automatic expect_tx(input string tag, input int bc, input logic nine,
                           input logic [7:0] d, input logic n9);
    logic [10:0] act;
    logic [10:0] exp;
    int nb;
    nb  = nine ? 11 : 10;
    act = '1;
    exp = {1'b1, (nine ? n9 : 1'b1), d, 1'b0};
    repeat (bc / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      act[i] = txd;
      if (i < nb - 1) repeat (bc) @(negedge clk);
    end
    chk(tag, {5'd0, act}, {5'd0, exp});
  endtask

  logic [7:0] rv;
  logic [7:0] last_buf;
  logic       all_high;

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R13 reset state
    rd(1'b1, rv); chk("R13 ctrl after reset", {8'd0, rv}, 16'h0000);
    rd(1'b0, rv); chk("R13 data after reset", {8'd0, rv}, 16'h0000);
    chk("R13 txd/irqs after reset", {13'd0, txd, tx_irq, rx_irq}, 16'h0004);

    // R1 R2 R5: mode 0 frame, a write in the middle is ignored
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hA6);
    fork
      expect_tx("R2 mode0 frame LSB first", 48, 1'b0, 8'hA6, 1'b0);
      begin repeat (150) @(negedge clk); wr(1'b0, 8'h0F); end
    join
    repeat (48) @(negedge clk);
    rd(1'b1, rv); chk("R6 tx done set", {15'd0, rv[1]}, 16'd1);
    all_high = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!txd) all_high = 1'b0;
    end
    chk("R5 write while busy ignored", {15'd0, all_high}, 16'd1);
    wr(1'b1, 8'h00);
    rd(1'b1, rv); chk("R6 tx done cleared by software", {15'd0, rv[1]}, 16'd0);

    // R3 R4: 9-bit fixed slow rate, ninth = 1
    rate_double = 1'b0;
    wr(1'b1, 8'h48);
    wr(1'b0, 8'h3B);
    expect_tx("R4 mode1 slow rate frame R3", 64, 1'b1, 8'h3B, 1'b1);
    repeat (100) @(negedge clk);
    rate_double = 1'b1;
    wr(1'b1, 8'h80);
    wr(1'b0, 8'hC4);
    expect_tx("R3 mode2 ninth=0 frame", 48, 1'b1, 8'hC4, 1'b0);
    repeat (100) @(negedge clk);

    // table: receive path R7 R9 R10
    last_buf = 8'h00;
    for (int v = 0; v < 9; v++) begin
      logic [1:0] m;
      int bc;
      m  = VEC[v][13:12];
      bc = bit_clks(m, 1'b1);
      wr(1'b1, {m, VEC[v][11], 5'b0});
      send_frame(bc, m != 2'd0, VEC[v][9:2], VEC[v][10], VEC[v][1]);
      repeat (2 * bc) @(negedge clk);
      rd(1'b1, rv);
      chk($sformatf("R7 R9 R10 vec%0d flag", v), {15'd0, rv[0]}, {15'd0, VEC[v][0]});
      if (VEC[v][0]) begin
        last_buf = VEC[v][9:2];
        if (m != 2'd0) chk($sformatf("R7 vec%0d ninth", v), {15'd0, rv[2]}, {15'd0, VEC[v][10]});
      end
      rd(1'b0, rv);
      chk($sformatf("R7 R9 R10 vec%0d buffer", v), {8'd0, rv}, {8'd0, last_buf});
    end

    // R8 glitch start
    wr(1'b1, 8'h00);
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (600) @(negedge clk);
    rd(1'b1, rv); chk("R8 glitch rejected flag", {15'd0, rv[0]}, 16'd0);
    rd(1'b0, rv); chk("R8 glitch buffer kept", {8'd0, rv}, {8'd0, last_buf});

    // R11 overwrite keeps flag
    send_frame(48, 1'b0, 8'h11, 1'b0, 1'b1);
    repeat (48) @(negedge clk);
    send_frame(48, 1'b0, 8'h22, 1'b0, 1'b1);
    repeat (96) @(negedge clk);
    rd(1'b1, rv); chk("R11 flag still set", {15'd0, rv[0]}, 16'd1);
    rd(1'b0, rv); chk("R11 buffer overwritten", {8'd0, rv}, 16'h0022);

    // R12 full duplex in mode 2
    wr(1'b1, 8'h88);
    wr(1'b0, 8'h5A);
    fork
      expect_tx("R12 tx during rx", 48, 1'b1, 8'h5A, 1'b1);
      send_frame(48, 1'b1, 8'h3C, 1'b1, 1'b1);
    join
    repeat (96) @(negedge clk);
    rd(1'b1, rv); chk("R12 both flags and ninth", {13'd0, rv[2:0]}, 16'h0007);
    rd(1'b0, rv); chk("R12 rx byte", {8'd0, rv}, 16'h003C);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule